// File: doc/BRIEF.md
# Locked Transaction Resource Tracker

This block sits in a bus bridge and keeps track of one exclusive lock. Each completed transaction is presented for one cycle with its initiator number, its address, its direction, and the state of the lock signal in two places: in the address phase and at the end of the transaction. A downstream transaction from a free state, with lock low in its address phase and high at its end, makes its initiator the lock owner. It also locks the 16-byte aligned block that holds its address.

While the lock is held, another initiator that reaches the locked block gets a retry in the same cycle, and the lock state does not change. Transactions that fall outside the block go through as normal, from any initiator. A flopped output turns off write posting in the bridge for as long as the lock is held. Upstream transactions never affect the lock and are never retried.

Top module: `lock_region_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `lock_held`, `lock_owner`, `lock_block` and `post_disable` to zero.
- R2: When no lock is held, a downstream valid transaction with `txn_lock_addr` low and `txn_lock_end` high sets `lock_held` at the next edge. At the same edge it loads `lock_owner` with `txn_master` and `lock_block` with `txn_addr[ADDR_W-1:4]`.
- R3: While a lock is held, a downstream valid transaction from a non-owner whose `txn_addr[ADDR_W-1:4]` equals `lock_block` raises `txn_retry` in the same cycle. The lock state is left unchanged.
- R4: `txn_retry` stays low for any transaction outside the locked block, and whenever no lock is held. Address bits 3:0 never take part in the comparison.
- R5: A downstream owner transaction to the locked block with `txn_lock_end` high keeps the lock, owner and block unchanged, and it is not retried.
- R6: A downstream owner transaction to the locked block with `txn_lock_end` low releases the lock at the next edge. `lock_owner` and `lock_block` return to zero.
- R7: A downstream owner transaction to any other block releases the lock at the next edge, whatever its lock flags are.
- R8: Transactions with `txn_downstream` low are never retried and never acquire, hold or release the lock.
- R9: `post_disable` is high in exactly the cycles in which `lock_held` is high.
- R10: With no lock held, a transaction with `txn_lock_addr` high does not acquire the lock. Cycles with `txn_valid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txn_valid | input | 1 | A transaction is presented this cycle |
| txn_master | input | MASTER_W | Initiator number |
| txn_addr | input | ADDR_W | Transaction byte address |
| txn_downstream | input | 1 | High when the transaction travels away from the host |
| txn_lock_addr | input | 1 | Lock signal level in the address phase |
| txn_lock_end | input | 1 | Lock signal level at the end of the transaction |
| txn_retry | output | 1 | Transaction must be retried (combinational) |
| lock_held | output | 1 | A lock is in force |
| lock_owner | output | MASTER_W | Initiator owning the lock |
| lock_block | output | ADDR_W-4 | Locked 16-byte block number |
| post_disable | output | 1 | Write posting must be turned off |

## Verification
The hardest case to reach is a non-owner that hits the locked block while other traffic around it goes through. The lock must already be in force and must not have been released by some earlier owner access. The bench takes the lock for every initiator in turn, on the lowest, a middle and the highest block of a narrow address space. It then sweeps every other initiator across the whole address range, with mixed lock flags and both directions. The owner ends each round by releasing through either the lock flag or a different block.

// File: rtl/lock_region_tracker.sv
module lock_region_tracker #(
  parameter int MASTER_W = 3,
  parameter int ADDR_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                txn_valid,
  input  logic [MASTER_W-1:0] txn_master,
  input  logic [ADDR_W-1:0]   txn_addr,
  input  logic                txn_downstream,
  input  logic                txn_lock_addr,
  input  logic                txn_lock_end,
  output logic                txn_retry,
  output logic                lock_held,
  output logic [MASTER_W-1:0] lock_owner,
  output logic [ADDR_W-5:0]   lock_block,
  output logic                post_disable
);
  localparam int GRAN = 4;
  localparam int BW   = ADDR_W - GRAN;

  logic [BW-1:0] blk;
  logic live, is_owner, hit, acquire, drop;

  assign blk      = txn_addr[ADDR_W-1:GRAN];
  assign live     = txn_valid & txn_downstream;
  assign is_owner = lock_held & (txn_master == lock_owner);
  assign hit      = lock_held & (blk == lock_block);
  assign txn_retry = live & hit & ~is_owner;
  assign acquire  = live & ~lock_held & ~txn_lock_addr & txn_lock_end;
  assign drop     = live & is_owner & (~hit | ~txn_lock_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_held    <= 1'b0;
      lock_owner   <= '0;
      lock_block   <= '0;
      post_disable <= 1'b0;
    end else if (acquire) begin
      lock_held    <= 1'b1;
      lock_owner   <= txn_master;
      lock_block   <= blk;
      post_disable <= 1'b1;
    end else if (drop) begin
      lock_held    <= 1'b0;
      lock_owner   <= '0;
      lock_block   <= '0;
      post_disable <= 1'b0;
    end
  end

  p_acquire_r2: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_downstream && !lock_held && !txn_lock_addr && txn_lock_end)
      |=> (lock_held && lock_owner == $past(txn_master)));

  p_retry_only_locked_r4: assert property (@(posedge clk) disable iff (rst)
    txn_retry |-> (lock_held && txn_valid && txn_downstream
                   && txn_addr[ADDR_W-1:GRAN] == lock_block));

  p_retry_no_change_r3: assert property (@(posedge clk) disable iff (rst)
    txn_retry |=> ($stable(lock_held) && $stable(lock_owner) && $stable(lock_block)));

  p_other_block_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && txn_downstream && lock_held && txn_master == lock_owner
     && txn_addr[ADDR_W-1:GRAN] != lock_block) |=> !lock_held);

  p_upstream_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && !txn_downstream) |=> ($stable(lock_held) && !$past(txn_retry)));

  p_post_follows_lock_r9: assert property (@(posedge clk) disable iff (rst)
    post_disable == lock_held);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !txn_valid |=> ($stable(lock_held) && $stable(lock_owner)));
endmodule

// File: tb/tb_lock_region_tracker.sv
`timescale 1ns/1ps
module tb_lock_region_tracker;
  localparam int MW = 2;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst;
  logic txn_valid, txn_downstream, txn_lock_addr, txn_lock_end;
  logic [MW-1:0] txn_master;
  logic [AW-1:0] txn_addr;
  logic txn_retry, lock_held, post_disable;
  logic [MW-1:0] lock_owner;
  logic [AW-5:0] lock_block;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit       m_held;
  int       m_owner, m_block;

  always #2.5 clk = ~clk;

  lock_region_tracker #(.MASTER_W(MW), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_master(txn_master),
    .txn_addr(txn_addr), .txn_downstream(txn_downstream),
    .txn_lock_addr(txn_lock_addr), .txn_lock_end(txn_lock_end),
    .txn_retry(txn_retry), .lock_held(lock_held), .lock_owner(lock_owner),
    .lock_block(lock_block), .post_disable(post_disable));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " held"}, lock_held, m_held);
    chk({tag, " owner"}, lock_owner, m_owner);
    chk({tag, " block"}, lock_block, m_block);
    chk("R9 post_disable", post_disable, m_held);
  endtask

  // One transaction: drive at negedge, check retry, let edge pass, check state.
  task automatic txn(input string tag, input bit v, input int m, input int a,
                     input bit dn, input bit la, input bit le);
    bit exp_retry, live, own;
    @(negedge clk);
    txn_valid = v; txn_master = MW'(m); txn_addr = AW'(a);
    txn_downstream = dn; txn_lock_addr = la; txn_lock_end = le;
    live = v && dn;
    own  = m_held && (m == m_owner);
    exp_retry = live && m_held && ((a >> 4) == m_block) && !own;
    #1 chk({tag, " retry"}, txn_retry, exp_retry);
    if (live && !m_held && !la && le) begin
      m_held = 1; m_owner = m; m_block = a >> 4;
    end else if (live && own && (((a >> 4) != m_block) || !le)) begin
      m_held = 0; m_owner = 0; m_block = 0;
    end
    @(negedge clk);
    txn_valid = 0;
    chk_state(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int blocks[3] = '{0, 5, 15};
    txn_valid = 0; txn_master = 0; txn_addr = 0;
    txn_downstream = 0; txn_lock_addr = 0; txn_lock_end = 0;
    rst = 1;
    m_held = 0; m_owner = 0; m_block = 0;
    repeat (2) @(negedge clk);
    chk_state("R1 reset");
    rst = 0;

    // R10: lock_addr high from free does not acquire; idle cycles change nothing
    txn("R10 busy-addr", 1, 1, 8'h37, 1, 1, 1);
    txn("R10 idle", 0, 2, 8'h40, 1, 0, 1);
    // R8: upstream acquire attempt ignored
    txn("R8 upstream acquire", 1, 2, 8'h40, 0, 0, 1);
    // R4: no retry while free
    txn("R4 free", 1, 0, 8'h41, 1, 0, 0);

    for (int o = 0; o < 4; o++) begin
      for (int bi = 0; bi < 3; bi++) begin
        int b = blocks[bi];
        txn("R2 acquire", 1, o, b * 16 + (o * 3 + bi) % 16, 1, 0, 1);
        txn("R10 idle held", 0, (o + 1) % 4, b * 16, 1, 0, 0);
        txn("R10 relock ignored", 1, (o + 1) % 4, ((b + 1) % 16) * 16, 1, 0, 1);
        for (int m = 0; m < 4; m++) begin
          if (m == o) continue;
          for (int a = 0; a < 256; a++) begin
            if ((a >> 4) == b) txn("R3 hit", 1, m, a, 1, a[0], a[1]);
            else if (a % 5 == 0) txn("R4 miss", 1, m, a, 1, a[0], a[1]);
          end
          for (int a = b * 16; a < b * 16 + 16; a += 4)
            txn("R8 upstream hit", 1, m, a, 0, 1, 1);
        end
        txn("R8 upstream owner", 1, o, ((b + 3) % 16) * 16, 0, 1, 0);
        txn("R5 owner continue", 1, o, b * 16 + 15, 1, 1, 1);
        txn("R5 owner continue", 1, o, b * 16, 1, 1, 1);
        if (bi == 1) txn("R7 owner other block", 1, o, ((b + 1) % 16) * 16, 1, 1, 1);
        else         txn("R6 owner release", 1, o, b * 16 + 7, 1, 1, 0);
        txn("R4 after release", 1, (o + 1) % 4, b * 16 + 2, 1, 1, 1);
        txn("R10 idle free", 0, 0, 0, 1, 0, 1);
      end
    end

    // R1: reset in the middle of a held lock
    txn("R2 acquire", 1, 3, 8'hA5, 1, 0, 1);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    m_held = 0; m_owner = 0; m_block = 0;
    chk_state("R1 reset mid-lock");
    txn("R4 after reset", 1, 1, 8'hA5, 1, 1, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule